// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block predicts the next fetch address. It is a direct-mapped table of branch entries. The fetch stage presents the address of the instruction being fetched. In the same cycle the block reads the entry selected by that address and compares the full stored tag against the address. It then returns the address to fetch next. That address is the stored target when the entry matches and its direction counter predicts taken. In every other case it is the fetch address plus four. A target that belongs to another branch is never followed.

When a branch resolves later in the pipeline, the resolution port reports the branch address, its actual target and whether it was taken. A matching entry has its two-bit saturating direction counter moved one step toward the outcome, and a taken outcome also refreshes the stored target. A taken branch that has no entry claims the slot at its index. The new entry is marked weakly taken. A not-taken branch without an entry leaves the table unchanged.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports no hit, no taken prediction, and a next address of fetch address plus four.
- R2: A lookup whose entry is invalid or whose stored tag differs yields lookupHit 0, predictTaken 0 and nextPc equal to fetchPc + 4.
- R3: A resolved taken branch that misses claims the entry at index PC[7:2], storing tag PC[31:8], target bits [31:2] and counter 2'b10 (weakly taken). A later lookup of that address hits, predicts taken and returns the target.
- R4: A resolved not-taken branch that misses changes nothing, including an existing entry of another tag at the same index.
- R5: A hit needs all of PC[31:8] to equal the stored tag. An address that shares the index bits but differs in any tag bit misses.
- R6: The counter encodes 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken, and bit 1 gives the prediction. A taken resolution on a hit increments the counter and saturates at 11. A not-taken resolution on a hit decrements it and saturates at 00. A hit whose counter is 00 or 01 reports lookupHit 1, predictTaken 0 and nextPc = fetchPc + 4.
- R7: A taken resolution on a hit overwrites the stored target. A not-taken resolution on a hit leaves the stored target unchanged.
- R8: A resolution takes effect at the next rising clock edge. A lookup in the same cycle sees the previous contents, and the change is visible from the following cycle.
- R9: A taken resolution that misses because another tag occupies its index replaces that entry with its own tag and target and a counter of 2'b10, so the old tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, clears all valid bits |
| fetchPc | input | 32 | Address of the instruction being fetched |
| nextPc | output | 32 | Predicted next fetch address |
| lookupHit | output | 1 | Entry at the fetch index is valid and its tag matches |
| predictTaken | output | 1 | Hit with a counter predicting taken, so nextPc is the stored target |
| updValid | input | 1 | A branch resolution is presented this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTarget | input | 32 | Actual target of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 for taken |

## Verification
Lookup results depend only on fetchPc and the stored table, so they are due in the same cycle. The bench sets fetchPc in the low clock phase and samples one nanosecond later, well before the next edge. A resolution changes the table at exactly one rising edge. The bench therefore probes the same address while the resolution is still being driven, expecting the old contents, and probes again after the edge, expecting the new ones. Sweeps over all 64 indices, fixed counter walks and a long pseudo-random run are scored against a table model kept in the bench.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'b10;

  typedef struct packed {
    logic allocate;
    logic countUp;
    logic countDown;
    logic writeTarget;
    logic takeTarget;
  } ftb_strobe_t;

  function automatic ctr_t ctrUp(input ctr_t c);
    return (c == 2'b11) ? c : c + 2'b01;
  endfunction

  function automatic ctr_t ctrDown(input ctr_t c);
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/ftb_datapath.sv
module ftb_datapath
  import ftb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int OFS_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic [PC_W-1:0]   updTarget,
  input  ftb_strobe_t       strobe,
  output logic              lkHit,
  output logic              lkCtrMsb,
  output logic              updHit,
  output logic [PC_W-1:0]   nextPc
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W - OFS_W;
  localparam int TGT_W   = PC_W - OFS_W;

  logic [IDX_W-1:0] fetchIdx, updIdx;
  logic [TAG_W-1:0] fetchTag, updTag;

  assign fetchIdx = fetchPc[OFS_W +: IDX_W];
  assign fetchTag = fetchPc[PC_W-1 -: TAG_W];
  assign updIdx   = updPc[OFS_W +: IDX_W];
  assign updTag   = updPc[PC_W-1 -: TAG_W];

  logic unusedLowBits;
  assign unusedLowBits = ^{updPc[OFS_W-1:0], updTarget[OFS_W-1:0]};

  logic [ENTRIES-1:0] validVec;
  logic [TAG_W-1:0]   tagArr [ENTRIES];
  logic [TGT_W-1:0]   tgtArr [ENTRIES];
  ctr_t               ctrArr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic             validQ;
    logic [TAG_W-1:0] tagQ;
    logic [TGT_W-1:0] tgtQ;
    ctr_t             ctrQ;
    logic             slotSel;

    assign slotSel = (updIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
      end else if (slotSel && strobe.allocate) begin
        validQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (slotSel) begin
        if (strobe.allocate) begin
          tagQ <= updTag;
        end
        if (strobe.allocate || strobe.writeTarget) begin
          tgtQ <= updTarget[PC_W-1:OFS_W];
        end
        if (strobe.allocate) begin
          ctrQ <= CTR_WEAK_TAKEN;
        end else if (strobe.countUp) begin
          ctrQ <= ctrUp(ctrQ);
        end else if (strobe.countDown) begin
          ctrQ <= ctrDown(ctrQ);
        end
      end
    end

    assign validVec[e] = validQ;
    assign tagArr[e]   = tagQ;
    assign tgtArr[e]   = tgtQ;
    assign ctrArr[e]   = ctrQ;
  end

  logic [TGT_W-1:0] lkTarget;
  ctr_t             lkCtr;

  always_comb begin
    lkHit    = validVec[fetchIdx] && (tagArr[fetchIdx] == fetchTag);
    lkCtr    = ctrArr[fetchIdx];
    lkCtrMsb = lkCtr[1];
    lkTarget = tgtArr[fetchIdx];
    updHit   = validVec[updIdx] && (tagArr[updIdx] == updTag);
  end

  always_comb begin
    if (strobe.takeTarget) begin
      nextPc = {lkTarget, {OFS_W{1'b0}}};
    end else begin
      nextPc = fetchPc + PC_W'(4);
    end
  end

endmodule

// File: rtl/ftb_control.sv
module ftb_control
  import ftb_pkg::*;
(
  input  logic        updValid,
  input  logic        updTaken,
  input  logic        updHit,
  input  logic        lkHit,
  input  logic        lkCtrMsb,
  output ftb_strobe_t strobe
);

  always_comb begin
    strobe             = '0;
    strobe.allocate    = updValid && updTaken && !updHit;
    strobe.countUp     = updValid && updTaken && updHit;
    strobe.countDown   = updValid && !updTaken && updHit;
    strobe.writeTarget = updValid && updTaken && updHit;
    strobe.takeTarget  = lkHit && lkCtrMsb;
  end

endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
  import ftb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic [PC_W-1:0] nextPc,
  output logic            lookupHit,
  output logic            predictTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updTaken
);

  localparam int OFS_W = 2;

  ftb_strobe_t strobe;
  logic        lkHit, lkCtrMsb, updHit;

  ftb_control u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updHit   (updHit),
    .lkHit    (lkHit),
    .lkCtrMsb (lkCtrMsb),
    .strobe   (strobe)
  );

  ftb_datapath #(
    .PC_W  (PC_W),
    .IDX_W (IDX_W),
    .OFS_W (OFS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fetchPc   (fetchPc),
    .updPc     (updPc),
    .updTarget (updTarget),
    .strobe    (strobe),
    .lkHit     (lkHit),
    .lkCtrMsb  (lkCtrMsb),
    .updHit    (updHit),
    .nextPc    (nextPc)
  );

  assign lookupHit    = lkHit;
  assign predictTaken = strobe.takeTarget;

endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic [PC_W-1:0] nextPc,
  input logic            lookupHit,
  input logic            predictTaken,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic [PC_W-1:0] updTarget,
  input logic            updTaken
);

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !lookupHit);

  assert_miss_falls_through_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (nextPc == fetchPc + PC_W'(4)) && !predictTaken);

  assert_taken_resolve_hits_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(updValid && updTaken && (updPc == fetchPc)) && $stable(fetchPc)) |-> lookupHit);

  assert_not_taken_no_alloc_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(updValid && !updTaken && (updPc == fetchPc) && !lookupHit) && $stable(fetchPc))
      |-> !lookupHit);

  assert_taken_needs_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    predictTaken |-> lookupHit);

  assert_target_refresh_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(updValid && updTaken && (updPc == fetchPc) && predictTaken) && $stable(fetchPc))
      |-> predictTaken && (nextPc[PC_W-1:2] == $past(updTarget[PC_W-1:2])));

endmodule

bind fetch_target_buffer ftb_checker #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchPc      (fetchPc),
  .nextPc       (nextPc),
  .lookupHit    (lookupHit),
  .predictTaken (predictTaken),
  .updValid     (updValid),
  .updPc        (updPc),
  .updTarget    (updTarget),
  .updTaken     (updTaken)
);

// File: tb/fetch_target_buffer_tb.sv
`timescale 1ns/1ps
module fetch_target_buffer_tb;

  localparam int ENTRIES = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  wire  [31:0] nextPc;
  wire         lookupHit;
  wire         predictTaken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          mValid [ENTRIES];
  logic [23:0] mTag   [ENTRIES];
  logic [29:0] mTgt   [ENTRIES];
  logic [1:0]  mCtr   [ENTRIES];

  always #4 clk = ~clk;

  fetch_target_buffer u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .fetchPc      (fetchPc),
    .nextPc       (nextPc),
    .lookupHit    (lookupHit),
    .predictTaken (predictTaken),
    .updValid     (updValid),
    .updPc        (updPc),
    .updTarget    (updTarget),
    .updTaken     (updTaken)
  );

  function automatic logic [31:0] pcFor(input int i);
    return 32'h0004_0000 | (32'(i) << 2);
  endfunction

  function automatic logic [31:0] tgtFor(input int i);
    return 32'h8000_1000 + 32'(i) * 32'h40;
  endfunction

  task automatic lookupCheck(input string req, input logic [31:0] pc);
    int          idx;
    bit          expHit, expTk;
    logic [31:0] expNext;
    idx     = int'(pc[7:2]);
    expHit  = mValid[idx] && (mTag[idx] == pc[31:8]);
    expTk   = expHit && mCtr[idx][1];
    expNext = expTk ? {mTgt[idx], 2'b00} : pc + 32'd4;
    fetchPc = pc;
    #1;
    checks++;
    if (lookupHit !== expHit || predictTaken !== expTk || nextPc !== expNext) begin
      fails++;
      $display("FAIL %s pc=%h hit=%b exp %b taken=%b exp %b nextPc=%h exp %h",
               req, pc, lookupHit, expHit, predictTaken, expTk, nextPc, expNext);
    end
  endtask

  task automatic modelApply(input logic [31:0] pc, input logic [31:0] tgt, input bit tk);
    int idx;
    bit hit;
    idx = int'(pc[7:2]);
    hit = mValid[idx] && (mTag[idx] == pc[31:8]);
    if (hit) begin
      if (tk) begin
        mCtr[idx] = (mCtr[idx] == 2'b11) ? 2'b11 : mCtr[idx] + 2'b01;
        mTgt[idx] = tgt[31:2];
      end else begin
        mCtr[idx] = (mCtr[idx] == 2'b00) ? 2'b00 : mCtr[idx] - 2'b01;
      end
    end else if (tk) begin
      mValid[idx] = 1'b1;
      mTag[idx]   = pc[31:8];
      mTgt[idx]   = tgt[31:2];
      mCtr[idx]   = 2'b10;
    end
  endtask

  // Drive one resolution; probe probePc in the same cycle (R8: old contents expected).
  task automatic resolve(input logic [31:0] pc, input logic [31:0] tgt, input bit tk,
                         input logic [31:0] probePc);
    @(negedge clk);
    updPc     = pc;
    updTarget = tgt;
    updTaken  = tk;
    updValid  = 1'b1;
    lookupCheck("R8 same-cycle", probePc);
    @(posedge clk);
    modelApply(pc, tgt, tk);
    #1;
    updValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired before the sequence completed");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 1'b0;
      mTag[i]   = '0;
      mTgt[i]   = '0;
      mCtr[i]   = '0;
    end
    repeat (4) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);

    // R1: every index empty after reset
    for (int i = 0; i < ENTRIES; i++) lookupCheck("R1 reset", pcFor(i));

    // R4: not-taken misses allocate nothing
    for (int i = 0; i < 8; i++) begin
      resolve(pcFor(i * 5), tgtFor(i), 1'b0, pcFor(i * 5));
      lookupCheck("R4 no-alloc", pcFor(i * 5));
    end

    // R3 + R8: allocate every index, probe same address in the resolving cycle
    for (int i = 0; i < ENTRIES; i++) begin
      resolve(pcFor(i), tgtFor(i), 1'b1, pcFor(i));
      lookupCheck("R3 allocate", pcFor(i));
    end
    for (int i = 0; i < ENTRIES; i++) lookupCheck("R3 sweep", pcFor(i));

    // R5 / R2: each single tag bit flipped misses
    for (int b = 8; b < 32; b++) begin
      lookupCheck("R5 tag bit", pcFor(b) ^ (32'd1 << b));
    end
    lookupCheck("R2 miss", 32'h1234_5678 & ~32'd3);

    // R4: not-taken conflicting tag leaves the resident entry
    resolve(pcFor(9) ^ 32'h0100_0000, 32'h4444_0000, 1'b0, pcFor(9));
    lookupCheck("R4 resident kept", pcFor(9));
    lookupCheck("R4 conflict miss", pcFor(9) ^ 32'h0100_0000);

    // R6: counter walk on entry 20 (starts at 10)
    for (int k = 0; k < 4; k++) begin
      resolve(pcFor(20), 32'h5555_0000, 1'b0, pcFor(20));
      lookupCheck("R6 down walk", pcFor(20));
    end
    for (int k = 0; k < 4; k++) begin
      resolve(pcFor(20), tgtFor(20), 1'b1, pcFor(20));
      lookupCheck("R6 up walk", pcFor(20));
    end
    resolve(pcFor(20), 32'h6666_0000, 1'b0, pcFor(20));
    lookupCheck("R6 strong hysteresis", pcFor(20));

    // R7: taken hit refreshes target, not-taken hit keeps it
    resolve(pcFor(30), 32'h7000_0040, 1'b1, pcFor(30));
    lookupCheck("R7 refresh", pcFor(30));
    resolve(pcFor(30), 32'h7abc_0000, 1'b0, pcFor(30));
    lookupCheck("R7 keep", pcFor(30));

    // R9: taken conflicting tag replaces the entry
    resolve(pcFor(40) ^ 32'h0020_0000, 32'h9000_0100, 1'b1, pcFor(40));
    lookupCheck("R9 new tag", pcFor(40) ^ 32'h0020_0000);
    lookupCheck("R9 old tag", pcFor(40));
    resolve(pcFor(40) ^ 32'h0020_0000, 32'h9000_0200, 1'b0, pcFor(40) ^ 32'h0020_0000);
    lookupCheck("R9 weak counter", pcFor(40) ^ 32'h0020_0000);

    // Mixed pseudo-random run over four tags per index
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pc, probe;
      lfsr  = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pc    = {22'd0, lfsr[9:2], 2'b00};
      probe = {22'd0, lfsr[19:12], 2'b00};
      resolve(pc, {lfsr[31:12], 12'h0} ^ {20'h0, lfsr[9:0], 2'b0}, lfsr[10] | lfsr[11], probe);
      lookupCheck("R6 R7 mixed", pc);
      lookupCheck("R2 R5 mixed", probe);
    end

    finishRun();
  end

endmodule